// File: doc/BRIEF.md
# Scan Vector Sequence Controller

This controller schedules a list of scan vectors for a separate shift engine. On a start pulse it raises a compare-initialise pulse. It then launches each vector, one at a time, by index. Each vector is issued as many times as its own repeat field asks before the index moves on. When the last vector's final repetition completes, one pass of the loop is over. The whole list is then run again, until the loop count is used up or the compare result of that closing vector reports a match.

The shift engine answers every launch with a one-cycle completion strobe and a compare verdict. Only the verdict that arrives with the strobe ending a loop can stop the sequence early. All other verdicts are ignored. At the end the controller pulses a done output and leaves the deciding verdict on a pass output. That output stays there until the next run starts. The configuration inputs must stay stable while a run is in progress.

Top module: `vseq_ctrl`

## Requirements
- R1: After reset, `launch`, `cmp_init` and `done` are low, `vec_idx` is 0, `pass` is 0, and the controller is idle.
- R2: A `start` pulse sampled while idle produces exactly one single-cycle `cmp_init` pulse on the next cycle. `pass` reads 0 during that pulse. The first `launch`, for index 0, follows in the cycle after.
- R3: Vectors are launched in ascending index order, from 0 to the last index. Vector i is launched back to back N times, where N is the 4-bit field `vec_rpt[4*i+3:4*i]`. A field value of 0 means one launch.
- R4: `vec_cnt` gives the number of vectors in the list. A value of 0 means one vector, and a value above MAX_VEC means MAX_VEC vectors.
- R5: Each `launch` is a single-cycle pulse. After a launch, no further launch occurs until a `vec_done` strobe has been received. The next launch comes in the cycle after that strobe. A `vec_done` that arrives while no vector is outstanding, including while idle, is ignored.
- R6: If no early exit occurs, the full list runs S times, where S is `seq_rpt`. A value of 0 means one pass.
- R7: The sequence stops early when `cmp_ok` is high with the `vec_done` that ends a loop pass. That is the final repetition of the last vector. Verdicts that arrive with any other strobe never stop the sequence.
- R8: `done` is a single-cycle pulse in the cycle after the terminating `vec_done`. At that point `pass` takes the `cmp_ok` value of that strobe and holds it until the next accepted start.
- R9: A `start` pulse while a run is in progress is ignored. It causes no extra `cmp_init`, no restart and no change to the launch order.
- R10: `vec_idx` changes only in a `launch` or `cmp_init` cycle. It stays stable while a vector is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (ignored while busy) |
| vec_cnt | input | $clog2(MAX_VEC)+1 | Number of vectors in the list |
| vec_rpt | input | MAX_VEC*RPT_W | Per-vector repeat fields, vector i at bits [RPT_W*i +: RPT_W] |
| seq_rpt | input | SEQ_W | Number of loop passes |
| vec_done | input | 1 | Shift engine finished the launched vector |
| cmp_ok | input | 1 | Compare verdict, valid with vec_done |
| vec_idx | output | $clog2(MAX_VEC) | Index of the current vector |
| launch | output | 1 | Pulse: shift vector vec_idx |
| cmp_init | output | 1 | Pulse: reinitialise compare state |
| done | output | 1 | Pulse: run finished |
| pass | output | 1 | Verdict of the terminating compare |

## Verification
The responder in the bench reports a match on every strobe except the one that closes a loop. A design that stopped on any other verdict, or on an earlier repetition of the last vector, would therefore quit too soon and leave expected launches unconsumed. Zero-valued repeat, vector and loop fields are driven to catch a design that skips a vector or wraps a counter and runs sixteen times. A stray `start` is sent mid-run to expose a restart, and a stray `vec_done` is sent while idle to expose a phantom launch. `pass` is sampled after termination and again when the next run's `cmp_init` appears. This catches a flag that is not cleared, or one that is updated by non-terminal verdicts.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_INIT   = 3'd1,
        SQ_LAUNCH = 3'd2,
        SQ_WAIT   = 3'd3,
        SQ_FIN    = 3'd4
    } vseq_state_e;

    typedef struct packed {
        logic launch;
        logic cmp_init;
        logic done;
    } vseq_pulse_t;

    // Decision taken when a vector completes
    typedef enum logic [1:0] {
        ST_REPEAT = 2'd0,
        ST_NEXT   = 2'd1,
        ST_LOOP   = 2'd2,
        ST_EXIT   = 2'd3
    } vseq_step_e;

    function automatic vseq_step_e pick_step(input logic rep_last,
                                             input logic vec_last,
                                             input logic seq_last,
                                             input logic cmp);
        if (!rep_last)          return ST_REPEAT;
        if (!vec_last)          return ST_NEXT;
        if (cmp || seq_last)    return ST_EXIT;
        return ST_LOOP;
    endfunction

endpackage

// File: rtl/vseq_loop_cnt.sv
module vseq_loop_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt;
    logic [W:0]   runs;
    logic [W:0]   lim_eff;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (step)
            cnt <= cnt + 1'b1;
    end

    always_comb begin
        runs    = {1'b0, cnt} + 1'b1;
        lim_eff = (limit == '0) ? {{W{1'b0}}, 1'b1} : {1'b0, limit};
        last    = (runs >= lim_eff);
    end
endmodule

// File: rtl/vseq_rpt_sel.sv
module vseq_rpt_sel #(
    parameter int N     = 8,
    parameter int W     = 4,
    parameter int IDX_W = 3
) (
    input  logic [N*W-1:0]   rpt_bus,
    input  logic [IDX_W-1:0] idx,
    output logic [W-1:0]     sel
);
    logic [W-1:0] fields [N];

    for (genvar g = 0; g < N; g++) begin : g_unpack
        assign fields[g] = rpt_bus[g*W +: W];
    end

    always_comb begin
        sel = '0;
        for (int i = 0; i < N; i++)
            if (idx == IDX_W'(i))
                sel = fields[i];
    end
endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
    import vseq_pkg::*;
#(
    parameter int MAX_VEC = 8,
    parameter int RPT_W   = 4,
    parameter int SEQ_W   = 4,
    localparam int IDX_W  = $clog2(MAX_VEC),
    localparam int CNT_W  = IDX_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [CNT_W-1:0]         vec_cnt,
    input  logic [MAX_VEC*RPT_W-1:0] vec_rpt,
    input  logic [SEQ_W-1:0]         seq_rpt,
    input  logic                     vec_done,
    input  logic                     cmp_ok,
    output logic [IDX_W-1:0]         vec_idx,
    output logic                     launch,
    output logic                     cmp_init,
    output logic                     done,
    output logic                     pass
);
    vseq_state_e       state;
    vseq_pulse_t       pulses;
    vseq_step_e        step_kind;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_idx;
    logic [RPT_W-1:0]  cur_rpt;
    logic              rep_last;
    logic              seq_last;
    logic              vec_fin;
    logic              rep_clr;
    logic              rep_step;
    logic              seq_step;

    // Last index of the list, zero meaning one vector, clamped to the array
    always_comb begin
        if (vec_cnt == '0)
            last_idx = '0;
        else if (vec_cnt > CNT_W'(MAX_VEC))
            last_idx = IDX_W'(MAX_VEC - 1);
        else
            last_idx = IDX_W'(vec_cnt - 1'b1);
    end

    vseq_rpt_sel #(.N(MAX_VEC), .W(RPT_W), .IDX_W(IDX_W)) u_sel (
        .rpt_bus (vec_rpt),
        .idx     (idx_q),
        .sel     (cur_rpt)
    );

    assign vec_fin   = (state == SQ_WAIT) && vec_done;
    assign step_kind = pick_step(rep_last, idx_q == last_idx, seq_last, cmp_ok);
    assign rep_clr   = (state == SQ_INIT) || (vec_fin && step_kind != ST_REPEAT);
    assign rep_step  = vec_fin && step_kind == ST_REPEAT;
    assign seq_step  = vec_fin && step_kind == ST_LOOP;

    vseq_loop_cnt #(.W(RPT_W)) u_rep (
        .clk   (clk),
        .rst   (rst),
        .clr   (rep_clr),
        .step  (rep_step),
        .limit (cur_rpt),
        .last  (rep_last)
    );

    vseq_loop_cnt #(.W(SEQ_W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .clr   (state == SQ_INIT),
        .step  (seq_step),
        .limit (seq_rpt),
        .last  (seq_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            idx_q <= '0;
            pass  <= 1'b0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (start) begin
                        state <= SQ_INIT;
                        idx_q <= '0;
                        pass  <= 1'b0;
                    end
                end
                SQ_INIT:   state <= SQ_LAUNCH;
                SQ_LAUNCH: state <= SQ_WAIT;
                SQ_WAIT: begin
                    if (vec_done) begin
                        unique case (step_kind)
                            ST_REPEAT: state <= SQ_LAUNCH;
                            ST_NEXT: begin
                                idx_q <= idx_q + 1'b1;
                                state <= SQ_LAUNCH;
                            end
                            ST_LOOP: begin
                                idx_q <= '0;
                                state <= SQ_LAUNCH;
                            end
                            ST_EXIT: begin
                                pass  <= cmp_ok;
                                state <= SQ_FIN;
                            end
                        endcase
                    end
                end
                SQ_FIN:  state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        pulses.launch   = (state == SQ_LAUNCH);
        pulses.cmp_init = (state == SQ_INIT);
        pulses.done     = (state == SQ_FIN);
    end

    assign launch   = pulses.launch;
    assign cmp_init = pulses.cmp_init;
    assign done     = pulses.done;
    assign vec_idx  = idx_q;
endmodule

// File: rtl/vseq_ctrl_chk.sv
module vseq_ctrl_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             vec_done,
    input logic [IDX_W-1:0] vec_idx,
    input logic             launch,
    input logic             cmp_init,
    input logic             done,
    input logic             pass
);
    logic outstanding;
    logic running;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding <= 1'b0;
            running     <= 1'b0;
        end else begin
            if (launch)        outstanding <= 1'b1;
            else if (vec_done) outstanding <= 1'b0;
            if (cmp_init)      running <= 1'b1;
            else if (done)     running <= 1'b0;
        end
    end

    // R1
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({launch, cmp_init, done}));

    // R2
    init_from_start_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_init |-> $past(start));

    // R2
    init_then_first_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_init |=> (launch && vec_idx == '0));

    // R5
    launch_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        launch |-> !outstanding);

    // R5
    launch_single_chk: assert property (@(posedge clk) disable iff (rst)
        launch |=> !launch);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(vec_done));

    // R8
    pass_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pass) |-> (done || cmp_init));

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_init |-> !running);

    // R10
    idx_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(vec_idx) |-> (launch || cmp_init));
endmodule

bind vseq_ctrl vseq_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .vec_done (vec_done),
    .vec_idx  (vec_idx),
    .launch   (launch),
    .cmp_init (cmp_init),
    .done     (done),
    .pass     (pass)
);

// File: tb/tb_vseq_ctrl.sv
module tb_vseq_ctrl;
    localparam int MAX_VEC = 8;
    localparam int RPT_W   = 4;
    localparam int SEQ_W   = 4;
    localparam int IDX_W   = 3;
    localparam int CNT_W   = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                     rst = 1'b1;
    logic                     start = 1'b0;
    logic [CNT_W-1:0]         vec_cnt = '0;
    logic [MAX_VEC*RPT_W-1:0] vec_rpt = '0;
    logic [SEQ_W-1:0]         seq_rpt = '0;
    logic                     vec_done = 1'b0;
    logic                     cmp_ok = 1'b0;
    logic [IDX_W-1:0]         vec_idx;
    logic                     launch, cmp_init, done, pass;

    vseq_ctrl #(.MAX_VEC(MAX_VEC), .RPT_W(RPT_W), .SEQ_W(SEQ_W)) dut (
        .clk(clk), .rst(rst), .start(start), .vec_cnt(vec_cnt),
        .vec_rpt(vec_rpt), .seq_rpt(seq_rpt), .vec_done(vec_done),
        .cmp_ok(cmp_ok), .vec_idx(vec_idx), .launch(launch),
        .cmp_init(cmp_init), .done(done), .pass(pass)
    );

    typedef struct { int idx; bit cmp; } item_t;
    item_t exp_q[$];

    int  checks = 0, fails = 0;
    int  rpt_cfg[MAX_VEC];
    int  done_seen = 0, init_seen = 0, run_launches = 0, cycles = 0;
    bit  inject = 0, pending = 0, cur_cmp = 0, prev_done = 0;
    int  dly = 0, cur_idx = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor and shift-engine responder: pops expected launches and answers them
    always @(negedge clk) begin
        vec_done = inject;
        cmp_ok   = 1'b0;
        if (!rst) begin
            if (cmp_init) begin
                init_seen++;
                chk(pass == 1'b0, "R2 pass cleared at cmp_init", pass, 0);
                chk(run_launches == 0, "R2 cmp_init before first launch", run_launches, 0);
            end
            if (done) begin
                done_seen++;
                chk(!prev_done, "R8 done single cycle", prev_done, 0);
            end
            prev_done = done;
            if (launch) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected extra launch", vec_idx, -1);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk(vec_idx == IDX_W'(it.idx), "R3 launch index", vec_idx, it.idx);
                    cur_cmp = it.cmp;
                    cur_idx = it.idx;
                    pending = 1'b1;
                    dly     = run_launches % 3;
                    run_launches++;
                end
            end else if (pending) begin
                if (dly == 0) begin
                    chk(vec_idx == IDX_W'(cur_idx), "R10 index stable while shifting", vec_idx, cur_idx);
                    vec_done = 1'b1;
                    cmp_ok   = cur_cmp;
                    pending  = 1'b0;
                end else begin
                    dly--;
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Driver: builds the expected launch list from the requirements, then runs
    task automatic run_seq(input int nvec, input int seq, input int pass_loop,
                           input bit extra_start, input string exit_req);
        int  n, loops, d0, i0, guard;
        bit  exp_pass, stop, sent;
        n     = (nvec == 0) ? 1 : ((nvec > MAX_VEC) ? MAX_VEC : nvec);
        loops = (seq == 0) ? 1 : seq;
        exp_pass = 1'b0;
        stop  = 1'b0;
        exp_q.delete();
        for (int l = 0; l < loops && !stop; l++) begin
            for (int v = 0; v < n && !stop; v++) begin
                int r;
                r = (rpt_cfg[v] == 0) ? 1 : rpt_cfg[v];
                for (int k = 0; k < r && !stop; k++) begin
                    item_t it;
                    bit closing;
                    closing = (v == n - 1) && (k == r - 1);
                    it.idx  = v;
                    it.cmp  = closing ? (l >= pass_loop) : 1'b1;
                    exp_q.push_back(it);
                    if (closing && (it.cmp || l == loops - 1)) begin
                        stop     = 1'b1;
                        exp_pass = it.cmp;
                    end
                end
            end
        end
        for (int v = 0; v < MAX_VEC; v++)
            vec_rpt[v*RPT_W +: RPT_W] = RPT_W'(rpt_cfg[v]);
        vec_cnt = CNT_W'(nvec);
        seq_rpt = SEQ_W'(seq);
        run_launches = 0;
        d0 = done_seen;
        i0 = init_seen;
        @(posedge clk); #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        guard = 0;
        sent  = 1'b0;
        while (done_seen == d0 && guard < 5000) begin
            @(posedge clk); #2;
            start = 1'b0;
            if (extra_start && !sent && run_launches >= 2) begin
                start = 1'b1;
                sent  = 1'b1;
            end
            guard++;
        end
        start = 1'b0;
        chk(done_seen == d0 + 1, "R8 done pulse seen", done_seen - d0, 1);
        chk(exp_q.size() == 0, exit_req, exp_q.size(), 0);
        chk(pass == exp_pass, "R8 pass verdict", pass, exp_pass);
        chk(init_seen == i0 + 1, "R9 single cmp_init per run", init_seen - i0, 1);
        repeat (5) @(posedge clk);
        #2;
        chk(pass == exp_pass, "R8 pass held after done", pass, exp_pass);
        chk(done_seen == d0 + 1, "R9 no restart after done", done_seen - d0, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk(!launch && !cmp_init && !done, "R1 pulses low in reset",
            {launch, cmp_init, done}, 0);
        rst = 1'b0;
        @(posedge clk); #2;
        chk(vec_idx == '0, "R1 index after reset", vec_idx, 0);
        chk(pass == 1'b0, "R1 pass after reset", pass, 0);
        chk(!done && !launch, "R1 idle after reset", {done, launch}, 0);

        // R5: stray strobes while idle produce nothing
        inject = 1'b1;
        repeat (3) @(posedge clk);
        #2 inject = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk(run_launches == 0 && done_seen == 0 && init_seen == 0,
            "R5 idle strobe ignored", run_launches + done_seen + init_seen, 0);

        // R4/R6/R7: zero vector count, zero loop count, passing compare
        foreach (rpt_cfg[i]) rpt_cfg[i] = 0;
        run_seq(0, 0, 0, 1'b0, "R4 single vector single pass");

        // R3/R6: mixed repeat fields (one zero), two loops, never passes
        foreach (rpt_cfg[i]) rpt_cfg[i] = 0;
        rpt_cfg[0] = 2; rpt_cfg[1] = 0; rpt_cfg[2] = 3;
        run_seq(3, 2, 99, 1'b0, "R6 all loops run without match");

        // R7: passes at end of second loop out of five
        foreach (rpt_cfg[i]) rpt_cfg[i] = 1;
        rpt_cfg[3] = 2;
        run_seq(4, 5, 1, 1'b0, "R7 early exit at loop boundary");

        // R9: stray start mid-run; three loops, match on the last
        foreach (rpt_cfg[i]) rpt_cfg[i] = 0;
        rpt_cfg[1] = 2;
        run_seq(2, 3, 2, 1'b1, "R9 run unaffected by busy start");

        // R4: count above the array size clamps to all vectors
        foreach (rpt_cfg[i]) rpt_cfg[i] = (i % 2) + 1;
        run_seq(12, 1, 0, 1'b0, "R4 clamped vector count");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule